// File: doc/BRIEF.md
# Scan-Accessed Temperature Probe Register

This block pairs a small temperature-probe model with the 4-bit test data register that reaches it from the scan path. The register works in the TCK domain. It can capture the probe's parallel reading, move data serially from `scan_in` to `scan_out`, and copy its shift stage into a parallel update stage. Bit 0 of the update stage is the probe's enable. A two-flop synchronizer carries that enable into the system clock domain.

When the synchronized enable is high, the probe counts system clocks. After a fixed number of them it presents its reading. When the enable goes low, the reading drops to zero and the count starts again. One access to the probe follows four steps:
- shift in a word with bit 0 set and update it, which starts a conversion;
- wait for the conversion to finish;
- capture the reading and shift it out;
- shift in and update a word with bit 0 clear, so the probe is ready for the next read.

Top module: `thermo_scan_tdr`

## Requirements
- R1: While `rst_n` is sampled low on both clocks, the update stage and the shift stage clear. After reset, `upd_q` is 0, `sensor_val` is 0 and `scan_out` is 0, so the probe starts disabled.
- R2: A rising TCK edge with `select` and `capture_en` high loads `sensor_val` into the shift stage.
- R3: A rising TCK edge with `select` and `shift_en` high, and `capture_en` low, moves `scan_in` into bit 3 and moves each bit one place toward bit 0. A word shifted in least-significant bit first therefore lands in the register, and the old contents leave on `scan_out` least-significant bit first.
- R4: `scan_out` is driven from shift-stage bit 0 and changes only on the falling TCK edge. It holds its value across the rising edge.
- R5: A rising TCK edge with `select` and `update_en` high copies the shift stage into `upd_q`. `upd_q[0]` is the probe enable.
- R6: While `select` is low, capture, shift and update have no effect on the register state or on `upd_q`.
- R7: The enable reaches the probe through two system-clock flops. After that, the reading appears 10 system clocks later. If `upd_q[0]` rises between system edges, `sensor_val` is 0 after the 11th following system edge and equals the reading code (4'b1011 by default) after the 12th.
- R8: When `upd_q[0]` falls, `sensor_val` returns to 0 after the second following system edge. A later enable waits the full delay again.
- R9: Capture takes priority over shift on the same edge. Update on the same edge as shift takes the shift stage as it was before that shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock that times the probe |
| tck | input | 1 | Test clock for the scan register |
| rst_n | input | 1 | Active-low reset, sampled synchronously on both clocks |
| select | input | 1 | Qualifies all register operations |
| capture_en | input | 1 | Parallel load of the probe reading |
| shift_en | input | 1 | Serial shift toward bit 0 |
| update_en | input | 1 | Copy of the shift stage into the update stage |
| scan_in | input | 1 | Serial data into bit 3 |
| scan_out | output | 1 | Serial data from bit 0, launched on falling TCK |
| upd_q | output | 4 | Update stage; bit 0 enables the probe |
| sensor_val | output | 4 | Probe reading, zero until the conversion completes |

## Verification
Two pairs of operations can fall on the same TCK edge, and the bench provokes both.

In the first, capture and shift are both asserted while the shift stage holds all ones and the probe reads zero. The shifted-out word then shows which operation won.

In the second, update and shift land on one edge. The bench compares the new `upd_q` with the word loaded before that edge, and the serial stream that follows with the word after the shift.

On the system side, the bench places the enable edge midway between system edges, so the 11th and 12th following edges bound the completion of the conversion exactly.

// File: rtl/probe_pkg.sv
// Package: shared width and operation encoding for the probe register.
// Assumes a single 4-bit data path between the register and the probe.
package probe_pkg;
    localparam int unsigned PROBE_W = 4;

    typedef enum logic [1:0] {
        SC_HOLD    = 2'd0,
        SC_CAPTURE = 2'd1,
        SC_SHIFT   = 2'd2
    } scan_op_e;
endpackage

// File: rtl/probe_sync.sv
// Multi-flop synchronizer for one level signal into the destination clock.
// Assumes the source changes no faster than a few destination cycles.
module probe_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/probe_sensor.sv
// Probe model: once the enable is high, counts DELAY clocks, then presents CODE.
// Assumes en_s is already synchronous to clk. The output is zero while not ready.
module probe_sensor #(
    parameter int unsigned W     = 4,
    parameter int unsigned DELAY = 10,
    parameter logic [W-1:0] CODE = 4'b1011
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_s,
    output logic [W-1:0] value
);
    localparam int unsigned CW = $clog2(DELAY + 1);
    localparam logic [CW-1:0] LAST = CW'(DELAY);

    logic [CW-1:0] cnt;
    logic          ready;

    // Count while enabled, saturate at the delay, clear when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_s) cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    // The reading is valid only while enabled and the delay has elapsed.
    always_comb begin
        ready = en_s && (cnt == LAST);
        value = ready ? CODE : '0;
    end

    // R8: a falling enable removes the reading at once.
    assert_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_s) |-> (value == '0));

    // R7: the count never passes the conversion delay.
    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R7: a reading that is present stays the same on the next edge while still enabled.
    assert_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && en_s) |=> (!en_s || $stable(value)));
endmodule

// File: rtl/probe_scan_reg.sv
// Capture/shift/update data register on the scan path, qualified by sel.
// Assumes control inputs are stable around rising TCK. Scan-out launches on falling TCK.
module probe_scan_reg
    import probe_pkg::*;
#(
    parameter int unsigned W = PROBE_W
) (
    input  logic         tck,
    input  logic         rst_n,
    input  logic         sel,
    input  logic         cap_en,
    input  logic         sh_en,
    input  logic         upd_en,
    input  logic         si,
    input  logic [W-1:0] par_in,
    output logic         so,
    output logic [W-1:0] upd_q
);
    logic [W-1:0] sr;
    scan_op_e     op;

    // Decode the shift-stage operation; capture outranks shift.
    always_comb begin
        op = SC_HOLD;
        if (sel) begin
            if (cap_en)     op = SC_CAPTURE;
            else if (sh_en) op = SC_SHIFT;
        end
    end

    // Shift stage: parallel capture or serial shift toward bit 0.
    always_ff @(posedge tck) begin
        if (!rst_n) sr <= '0;
        else begin
            case (op)
                SC_CAPTURE: sr <= par_in;
                SC_SHIFT:   sr <= {si, sr[W-1:1]};
                default:    sr <= sr;
            endcase
        end
    end

    // Update stage: copy the pre-edge shift stage when selected.
    always_ff @(posedge tck) begin
        if (!rst_n)              upd_q <= '0;
        else if (sel && upd_en)  upd_q <= sr;
    end

    // Launch bit 0 on the falling edge.
    always_ff @(negedge tck) begin
        if (!rst_n) so <= 1'b0;
        else        so <= sr[0];
    end

    assert_capture_R2: assert property (@(posedge tck) disable iff (!rst_n)
        (sel && cap_en) |=> (sr == $past(par_in)));

    assert_shift_R3: assert property (@(posedge tck) disable iff (!rst_n)
        (sel && sh_en && !cap_en) |=> (sr[W-2:0] == $past(sr[W-1:1])));

    assert_launch_R4: assert property (@(posedge tck) disable iff (!rst_n)
        so == sr[0]);

    assert_update_R5: assert property (@(posedge tck) disable iff (!rst_n)
        (sel && upd_en) |=> (upd_q == $past(sr)));

    assert_hold_R6: assert property (@(posedge tck) disable iff (!rst_n)
        !sel |=> ($stable(sr) && $stable(upd_q)));
endmodule

// File: rtl/thermo_scan_tdr.sv
// Top: scan data register whose update bit 0 enables a probe in the system domain.
// Assumes TCK and sys_clk are unrelated; only the enable crosses, via two flops.
module thermo_scan_tdr
    import probe_pkg::*;
#(
    parameter int unsigned DELAY = 10,
    parameter logic [PROBE_W-1:0] CODE = 4'b1011
) (
    input  logic               sys_clk,
    input  logic               tck,
    input  logic               rst_n,
    input  logic               select,
    input  logic               capture_en,
    input  logic               shift_en,
    input  logic               update_en,
    input  logic               scan_in,
    output logic               scan_out,
    output logic [PROBE_W-1:0] upd_q,
    output logic [PROBE_W-1:0] sensor_val
);
    localparam int unsigned SYNC_STAGES = 2;

    logic en_s;

    probe_scan_reg #(.W(PROBE_W)) u_reg (
        .tck    (tck),
        .rst_n  (rst_n),
        .sel    (select),
        .cap_en (capture_en),
        .sh_en  (shift_en),
        .upd_en (update_en),
        .si     (scan_in),
        .par_in (sensor_val),
        .so     (scan_out),
        .upd_q  (upd_q)
    );

    probe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (sys_clk),
        .rst_n (rst_n),
        .d     (upd_q[0]),
        .q     (en_s)
    );

    probe_sensor #(.W(PROBE_W), .DELAY(DELAY), .CODE(CODE)) u_sensor (
        .clk   (sys_clk),
        .rst_n (rst_n),
        .en_s  (en_s),
        .value (sensor_val)
    );
endmodule

// File: tb/tb_thermo_scan_tdr.sv
module tb_thermo_scan_tdr;
    localparam logic [3:0] CODE = 4'b1011;
    localparam int DELAY = 10;
    localparam int SYNC  = 2;

    logic sys_clk = 1'b0;
    logic tck = 1'b0;
    logic rst_n = 1'b0;
    logic select = 1'b0, capture_en = 1'b0, shift_en = 1'b0, update_en = 1'b0, scan_in = 1'b0;
    logic scan_out;
    logic [3:0] upd_q, sensor_val;

    int n_checks = 0;
    int n_fail = 0;

    thermo_scan_tdr #(.DELAY(DELAY), .CODE(CODE)) dut (
        .sys_clk(sys_clk), .tck(tck), .rst_n(rst_n), .select(select),
        .capture_en(capture_en), .shift_en(shift_en), .update_en(update_en),
        .scan_in(scan_in), .scan_out(scan_out), .upd_q(upd_q), .sensor_val(sensor_val)
    );

    always #2 sys_clk = ~sys_clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One TCK period: inputs set while TCK is low, rise and fall on system negedges.
    task automatic scan_cycle(input logic sel, input logic cap, input logic sh,
                              input logic upd, input logic si);
        logic pre;
        select = sel; capture_en = cap; shift_en = sh; update_en = upd; scan_in = si;
        @(negedge sys_clk);
        pre = scan_out;
        tck = 1'b1;
        #1;
        chk("R4 scan_out steady across rising edge", {7'd0, scan_out}, {7'd0, pre});
        @(negedge sys_clk);
        tck = 1'b0;
        #1;
        select = 1'b0; capture_en = 1'b0; shift_en = 1'b0; update_en = 1'b0; scan_in = 1'b0;
    endtask

    // Shift a word in LSB first while collecting the outgoing bits.
    task automatic shift_word(input logic sel, input logic [3:0] din, output logic [3:0] dout);
        for (int i = 0; i < 4; i++) begin
            dout[i] = scan_out;
            scan_cycle(sel, 1'b0, 1'b1, 1'b0, din[i]);
        end
    endtask

    // Update with the system-edge count of R7: 0 after edge 11, CODE after edge 12.
    task automatic timed_enable();
        select = 1'b1; update_en = 1'b1;
        @(negedge sys_clk);
        tck = 1'b1;
        @(posedge sys_clk);
        @(negedge sys_clk);
        tck = 1'b0;
        select = 1'b0; update_en = 1'b0;
        repeat (SYNC + DELAY - 2) @(posedge sys_clk);
        #1;
        chk("R7 reading absent after 11 system edges", {4'd0, sensor_val}, 8'd0);
        @(posedge sys_clk);
        #1;
        chk("R7 reading present after 12 system edges", {4'd0, sensor_val}, {4'd0, CODE});
        chk("R5 enable bit in update stage", {4'd0, upd_q}, 8'd1);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [3:0] got;
        logic [3:0] prev;

        // Reset in both domains.
        repeat (3) begin
            @(negedge sys_clk); tck = 1'b1;
            @(negedge sys_clk); tck = 1'b0;
        end
        repeat (3) @(posedge sys_clk);
        @(negedge sys_clk);
        rst_n = 1'b1;
        #1;
        chk("R1 update stage after reset", {4'd0, upd_q}, 8'd0);
        chk("R1 probe reading after reset", {4'd0, sensor_val}, 8'd0);
        chk("R1 scan_out after reset", {7'd0, scan_out}, 8'd0);

        // R3/R5 sweep over every word: shift in, update, and see the previous word shifted out.
        prev = 4'd0;
        for (int v = 0; v < 16; v++) begin
            shift_word(1'b1, 4'(v), got);
            chk("R3 serial stream returns previous word", {4'd0, got}, {4'd0, prev});
            scan_cycle(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
            chk("R5 update loads shifted word", {4'd0, upd_q}, 8'(v));
            prev = 4'(v);
        end

        // R6: with select low, nothing changes.
        scan_cycle(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        scan_cycle(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        scan_cycle(1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        chk("R6 update stage unchanged while unselected", {4'd0, upd_q}, 8'hF);
        shift_word(1'b1, 4'd0, got);
        chk("R6 shift stage unchanged while unselected", {4'd0, got}, 8'hF);
        scan_cycle(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        repeat (20) @(posedge sys_clk);
        #1;
        chk("R8 probe idle after disable", {4'd0, sensor_val}, 8'd0);

        // R7: start a conversion and time it.
        shift_word(1'b1, 4'b0001, got);
        timed_enable();

        // R2: capture the reading and shift it out.
        scan_cycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        shift_word(1'b1, 4'd0, got);
        chk("R2 captured reading shifted out", {4'd0, got}, {4'd0, CODE});

        // R8: disable, and the reading drops on the second system edge.
        select = 1'b1; update_en = 1'b1;
        @(negedge sys_clk);
        tck = 1'b1;
        @(posedge sys_clk);
        #1;
        chk("R8 reading held one edge after disable", {4'd0, sensor_val}, {4'd0, CODE});
        @(negedge sys_clk);
        tck = 1'b0;
        select = 1'b0; update_en = 1'b0;
        @(posedge sys_clk);
        #1;
        chk("R8 reading gone two edges after disable", {4'd0, sensor_val}, 8'd0);
        scan_cycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        shift_word(1'b1, 4'd0, got);
        chk("R8 capture after disable reads zero", {4'd0, got}, 8'd0);

        // R9: capture beats shift on the same edge.
        shift_word(1'b1, 4'hF, got);
        scan_cycle(1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        shift_word(1'b1, 4'd0, got);
        chk("R9 capture wins over shift", {4'd0, got}, 8'd0);

        // R9: update and shift on one edge.
        shift_word(1'b1, 4'b0110, got);
        scan_cycle(1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        chk("R9 update takes pre-shift word", {4'd0, upd_q}, 8'h6);
        shift_word(1'b1, 4'd0, got);
        chk("R9 shift proceeds alongside update", {4'd0, got}, 8'hB);

        // R8: a short enable, then a re-enable, waits the full delay again.
        shift_word(1'b1, 4'b0001, got);
        scan_cycle(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        scan_cycle(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R8 short enable cleared", {4'd0, upd_q}, 8'd0);
        repeat (6) @(posedge sys_clk);
        #1;
        chk("R8 no reading from short enable", {4'd0, sensor_val}, 8'd0);
        shift_word(1'b1, 4'b0001, got);
        timed_enable();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule